// File: doc/BRIEF.md
# PCIe Completer Write Request Streamer

This block takes one memory-write request at a time and turns it into a single packet on a 512-bit AXI4-Stream request channel toward user logic. The request arrives as a set of descriptor fields: a Dword address, a Dword count, and the byte-enable nibbles for the first and last payload Dwords. The payload then follows on a narrow input one Dword per handshake. The output packet starts with a 16-byte descriptor in Dword lanes 0 to 3. The payload follows in the same stream. Each beat carries per-Dword keep bits, per-byte enables, start-of-packet and last flags, and the two byte-enable nibbles as sideband.

Each request selects one of two payload placements. In Dword-aligned placement the payload starts directly after the descriptor, and the byte offset inside the first Dword is given only by the byte enables. In address-aligned placement the first payload Dword sits in the second 128-bit quarter of the first beat, at the lane named by the two low Dword-address bits. The lanes between the descriptor and the payload are null lanes that keep still covers. Downstream backpressure is honoured. The packet is built one beat at a time in a lane buffer and is released when the beat is full or the payload ends.

Top module: `cq_wr_streamer`

## Requirements
- R1: The first beat carries the descriptor in Dword lanes 0 to 3 (bits 127:0). Descriptor bits [63:2] hold the Dword address, bits [74:64] hold the Dword count (1 for a zero-length write), and all other descriptor bits are 0. Descriptor bytes never have a byte enable set.
- R2: While `m_valid` is high and `m_ready` is low, `m_valid` stays high and `m_data` and `m_keep` do not change.
- R3: `m_keep` is set contiguously from lane 0 of the first beat through the last payload Dword, null lanes included. Every beat except the final one has all 16 keep bits set. Lanes past the end of the packet have keep 0 and data 0.
- R4: `m_last` is high on the final beat of the packet and on no other beat.
- R5: `m_sop`, `m_first_be` and `m_last_be` are non-zero only in the first beat. `m_first_be` equals the request's first nibble. `m_last_be` equals the last nibble for writes of two or more Dwords and is 0 otherwise.
- R6: Byte enables (bit 4*lane+b for byte b of a lane) are set only for payload bytes. The first payload Dword uses the first nibble, the last payload Dword of a longer write uses the last nibble, and middle Dwords use 4'hF. A one-Dword write uses the first nibble only.
- R7: A request with `req_dwords` = 0 is a zero-length write. It is sent as one payload Dword with data 0 and all byte enables 0, and it never raises `pl_ready`.
- R8: With `req_aligned` = 0 the first payload Dword is in lane 4 of the first beat.
- R9: With `req_aligned` = 1 the first payload Dword is in lane 4 + `req_addr[1:0]`. The null lanes before it have keep 1, data 0 and byte enables 0.
- R10: Payload Dword i goes to overall lane position start + i, that is lane (start + i) mod 16 of beat (start + i) / 16, in arrival order.
- R11: `req_ready` is high only when no packet is in progress. A new request is taken only after the final beat has been transferred with `m_ready` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request fields are valid |
| req_ready | output | 1 | Streamer is idle and takes a request |
| req_addr | input | 62 | Dword address of the first payload Dword |
| req_dwords | input | 11 | Payload Dword count; 0 means a zero-length write |
| req_first_be | input | 4 | Byte enables of the first payload Dword |
| req_last_be | input | 4 | Byte enables of the last payload Dword |
| req_aligned | input | 1 | 1 selects address-aligned placement, 0 selects Dword-aligned |
| pl_valid | input | 1 | Payload Dword is valid |
| pl_ready | output | 1 | Streamer takes a payload Dword |
| pl_data | input | 32 | Payload Dword |
| m_valid | output | 1 | Output beat is valid |
| m_ready | input | 1 | Consumer takes the beat |
| m_data | output | 512 | Beat data, lane n in bits 32n+31:32n |
| m_keep | output | 16 | One keep bit per Dword lane |
| m_be | output | 64 | One enable per byte lane, payload bytes only |
| m_sop | output | 1 | First beat of a packet |
| m_first_be | output | 4 | First-Dword byte enables, first beat only |
| m_last_be | output | 4 | Last-Dword byte enables, first beat only |
| m_last | output | 1 | Final beat of a packet |

## Verification
The directed packets mix both placements with every start offset class. One-Dword and two-Dword writes separate the short byte-enable encodings from the long-write rule. A zero-length write shows the synthetic Dword and that payload input stays closed. Long writes of 28, 47 and 12 Dwords give a full final beat, a four-beat packet with a partial tail, and a packet of exactly one full beat. They show how beat boundaries, keep and last relate. Irregular backpressure on the long packets checks that beats are held and that requests stay blocked until the final handshake.

// File: rtl/cqws_pkg.sv
package cqws_pkg;
  localparam int DESC_DW = 4;
  localparam int ADDR_W  = 62;
  localparam int CNT_W   = 11;

  typedef enum logic [1:0] {ST_IDLE, ST_FILL, ST_SEND} cqws_state_e;

  // lane index of the first payload Dword inside the first beat
  function automatic int unsigned first_lane(logic aligned, logic [1:0] addr_lo);
    return DESC_DW + (aligned ? int'(addr_lo) : 0);
  endfunction

  // byte enables of one payload Dword
  function automatic logic [3:0] dword_be(logic zero_len, logic is_first, logic is_last,
                                          logic [3:0] fbe, logic [3:0] lbe);
    if (zero_len)      return 4'h0;
    else if (is_first) return fbe;
    else if (is_last)  return lbe;
    else               return 4'hF;
  endfunction

  // simplified 128-bit descriptor
  function automatic logic [127:0] desc_pack(logic [ADDR_W-1:0] addr, logic [CNT_W-1:0] cnt);
    logic [127:0] d;
    d = '0;
    d[63:2]  = addr;
    d[74:64] = cnt;
    return d;
  endfunction
endpackage

// File: rtl/cqws_ctrl.sv
module cqws_ctrl
  import cqws_pkg::*;
#(
  parameter int LANES  = 16,
  localparam int LANE_W = $clog2(LANES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_addr_lo,
  input  logic [CNT_W-1:0]  req_dwords,
  input  logic [3:0]        req_first_be,
  input  logic [3:0]        req_last_be,
  input  logic              req_aligned,
  input  logic              pl_valid,
  output logic              pl_ready,
  input  logic [31:0]       pl_data,
  input  logic              m_ready,
  output logic              out_valid,
  output logic              out_last,
  output logic              out_sop,
  output logic [3:0]        out_first_be,
  output logic [3:0]        out_last_be,
  output logic              load_desc,
  output logic [LANE_W-1:0] start_lane,
  output logic              wr_en,
  output logic [LANE_W-1:0] wr_lane,
  output logic [31:0]       wr_data,
  output logic [3:0]        wr_be,
  output logic              buf_clr
);
  cqws_state_e       st;
  logic [CNT_W-1:0]  rem;
  logic [LANE_W-1:0] lane;
  logic              zero_q, one_q, first_q, last_q, sop_q;
  logic [3:0]        fbe_q, lbe_q;
  logic              acc, beat_full, final_dw, out_fire;

  assign req_ready  = (st == ST_IDLE);
  assign acc        = req_valid & req_ready;
  assign load_desc  = acc;
  assign start_lane = LANE_W'(first_lane(req_aligned, req_addr_lo));

  assign pl_ready  = (st == ST_FILL) && !zero_q;
  assign wr_en     = (st == ST_FILL) && (zero_q || pl_valid);
  assign wr_lane   = lane;
  assign wr_data   = zero_q ? 32'h0 : pl_data;
  assign final_dw  = (rem == CNT_W'(1));
  assign beat_full = (lane == LANE_W'(LANES - 1));
  assign wr_be     = dword_be(zero_q, first_q, final_dw, fbe_q, lbe_q);

  assign out_valid    = (st == ST_SEND);
  assign out_fire     = out_valid & m_ready;
  assign buf_clr      = out_fire;
  assign out_last     = out_valid & last_q;
  assign out_sop      = out_valid & sop_q;
  assign out_first_be = out_sop ? fbe_q : 4'h0;
  assign out_last_be  = (out_sop && !one_q) ? lbe_q : 4'h0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      rem     <= '0;
      lane    <= '0;
      zero_q  <= 1'b0;
      one_q   <= 1'b0;
      first_q <= 1'b0;
      last_q  <= 1'b0;
      sop_q   <= 1'b0;
      fbe_q   <= 4'h0;
      lbe_q   <= 4'h0;
    end else begin
      case (st)
        ST_IDLE: if (acc) begin
          st      <= ST_FILL;
          lane    <= start_lane;
          rem     <= (req_dwords == '0) ? CNT_W'(1) : req_dwords;
          zero_q  <= (req_dwords == '0);
          one_q   <= (req_dwords <= CNT_W'(1));
          first_q <= 1'b1;
          sop_q   <= 1'b1;
          last_q  <= 1'b0;
          fbe_q   <= req_first_be;
          lbe_q   <= req_last_be;
        end
        ST_FILL: if (wr_en) begin
          lane    <= beat_full ? '0 : lane + LANE_W'(1);
          rem     <= rem - CNT_W'(1);
          first_q <= 1'b0;
          if (final_dw || beat_full) begin
            st     <= ST_SEND;
            last_q <= final_dw;
          end
        end
        ST_SEND: if (out_fire) begin
          sop_q <= 1'b0;
          st    <= last_q ? ST_IDLE : ST_FILL;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // a beat that is not final must keep the request port closed
  assert_req_blocked_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (out_fire && !out_last) |=> !req_ready);
  // a zero-length write never asks for payload
  assert_zero_no_payload_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_dwords == '0) |=> !pl_ready);
endmodule

// File: rtl/cqws_beat_buf.sv
module cqws_beat_buf
  import cqws_pkg::*;
#(
  parameter int LANES  = 16,
  localparam int LANE_W = $clog2(LANES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_desc,
  input  logic [LANE_W-1:0] start_lane,
  input  logic [127:0]      desc,
  input  logic              wr_en,
  input  logic [LANE_W-1:0] wr_lane,
  input  logic [31:0]       wr_data,
  input  logic [3:0]        wr_be,
  input  logic              buf_clr,
  output logic [LANES*32-1:0] data_o,
  output logic [LANES-1:0]    keep_o,
  output logic [LANES*4-1:0]  be_o
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [31:0] d_q;
    logic        k_q;
    logic [3:0]  b_q;

    if (g < DESC_DW) begin : g_desc
      always_ff @(posedge clk) begin
        if (!rst_n || buf_clr) begin
          d_q <= '0; k_q <= 1'b0; b_q <= '0;
        end else if (load_desc) begin
          d_q <= desc[g*32 +: 32]; k_q <= 1'b1; b_q <= '0;
        end else if (wr_en && wr_lane == LANE_W'(g)) begin
          d_q <= wr_data; k_q <= 1'b1; b_q <= wr_be;
        end
      end
    end else begin : g_body
      always_ff @(posedge clk) begin
        if (!rst_n || buf_clr) begin
          d_q <= '0; k_q <= 1'b0; b_q <= '0;
        end else if (load_desc) begin
          d_q <= '0; k_q <= (LANE_W'(g) < start_lane); b_q <= '0;
        end else if (wr_en && wr_lane == LANE_W'(g)) begin
          d_q <= wr_data; k_q <= 1'b1; b_q <= wr_be;
        end
      end
    end

    assign data_o[g*32 +: 32] = d_q;
    assign keep_o[g]          = k_q;
    assign be_o[g*4 +: 4]     = b_q;

    // an enabled byte must lie in a kept lane
    assert_be_in_keep_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (b_q != 4'h0) |-> k_q);
  end
endmodule

// File: rtl/cq_wr_streamer.sv
module cq_wr_streamer
  import cqws_pkg::*;
#(
  parameter int LANES  = 16,
  localparam int LANE_W = $clog2(LANES),
  localparam int DATA_W = LANES * 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [CNT_W-1:0]  req_dwords,
  input  logic [3:0]        req_first_be,
  input  logic [3:0]        req_last_be,
  input  logic              req_aligned,
  input  logic              pl_valid,
  output logic              pl_ready,
  input  logic [31:0]       pl_data,
  output logic              m_valid,
  input  logic              m_ready,
  output logic [DATA_W-1:0] m_data,
  output logic [LANES-1:0]  m_keep,
  output logic [LANES*4-1:0] m_be,
  output logic              m_sop,
  output logic [3:0]        m_first_be,
  output logic [3:0]        m_last_be,
  output logic              m_last
);
  logic              load_desc, wr_en, buf_clr;
  logic [LANE_W-1:0] start_lane, wr_lane;
  logic [31:0]       wr_data;
  logic [3:0]        wr_be;
  logic [127:0]      desc;

  assign desc = desc_pack(req_addr, (req_dwords == '0) ? CNT_W'(1) : req_dwords);

  cqws_ctrl #(.LANES(LANES)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_addr_lo(req_addr[1:0]), .req_dwords(req_dwords),
    .req_first_be(req_first_be), .req_last_be(req_last_be),
    .req_aligned(req_aligned),
    .pl_valid(pl_valid), .pl_ready(pl_ready), .pl_data(pl_data),
    .m_ready(m_ready), .out_valid(m_valid), .out_last(m_last),
    .out_sop(m_sop), .out_first_be(m_first_be), .out_last_be(m_last_be),
    .load_desc(load_desc), .start_lane(start_lane),
    .wr_en(wr_en), .wr_lane(wr_lane), .wr_data(wr_data), .wr_be(wr_be),
    .buf_clr(buf_clr)
  );

  cqws_beat_buf #(.LANES(LANES)) u_buf (
    .clk(clk), .rst_n(rst_n),
    .load_desc(load_desc), .start_lane(start_lane), .desc(desc),
    .wr_en(wr_en), .wr_lane(wr_lane), .wr_data(wr_data), .wr_be(wr_be),
    .buf_clr(buf_clr),
    .data_o(m_data), .keep_o(m_keep), .be_o(m_be)
  );

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_data) && $stable(m_keep)));
  assert_mid_keep_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_last) |-> (&m_keep));
  assert_keep_contig_R3: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid |-> ((m_keep & (m_keep + LANES'(1))) == '0));
  assert_sop_desc_R1: assert property (@(posedge clk) disable iff (!rst_n)
    m_sop |-> (m_keep[DESC_DW-1:0] == '1 && m_be[DESC_DW*4-1:0] == '0));
  assert_side_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !m_sop |-> (m_first_be == 4'h0 && m_last_be == 4'h0));
endmodule

// File: tb/sim_cq_wr_streamer.sv
module sim_cq_wr_streamer;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req_valid = 1'b0, req_aligned = 1'b0;
  logic [61:0]  req_addr = '0;
  logic [10:0]  req_dwords = '0;
  logic [3:0]   req_first_be = '0, req_last_be = '0;
  logic         pl_valid = 1'b0;
  logic [31:0]  pl_data = '0;
  logic         m_ready = 1'b1;
  logic         req_ready, pl_ready, m_valid, m_sop, m_last;
  logic [511:0] m_data;
  logic [15:0]  m_keep;
  logic [63:0]  m_be;
  logic [3:0]   m_first_be, m_last_be;

  int total = 0, bad = 0;
  bit all_done = 1'b0;

  logic [61:0] c_addr;
  int          c_n;
  logic [3:0]  c_f, c_l;
  bit          c_al, c_stall;

  always #5 clk = ~clk;

  cq_wr_streamer u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_dwords(req_dwords), .req_first_be(req_first_be),
    .req_last_be(req_last_be), .req_aligned(req_aligned),
    .pl_valid(pl_valid), .pl_ready(pl_ready), .pl_data(pl_data),
    .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data), .m_keep(m_keep),
    .m_be(m_be), .m_sop(m_sop), .m_first_be(m_first_be), .m_last_be(m_last_be),
    .m_last(m_last)
  );

  task automatic chk(string req, logic [511:0] act, logic [511:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] pat(int i);
    return 32'hC3A50000 ^ (i * 32'h01010101);
  endfunction
  function automatic int e_start();
    return 4 + (c_al ? int'(c_addr[1:0]) : 0);
  endfunction
  function automatic int e_len();
    return e_start() + ((c_n == 0) ? 1 : c_n);
  endfunction
  function automatic int e_beats();
    return (e_len() + 15) / 16;
  endfunction
  function automatic logic [31:0] e_dw(int g);
    logic [127:0] d;
    d = '0;
    d[63:2]  = c_addr;
    d[74:64] = (c_n == 0) ? 11'd1 : 11'(c_n);
    if (g < 4) return d[g*32 +: 32];
    if (g < e_start() || g >= e_len() || c_n == 0) return 32'h0;
    return pat(g - e_start());
  endfunction
  function automatic logic [3:0] e_be(int g);
    int idx;
    if (g < e_start() || g >= e_len() || c_n == 0) return 4'h0;
    idx = g - e_start();
    if (idx == 0) return c_f;
    if (idx == c_n - 1) return c_l;
    return 4'hF;
  endfunction

  task automatic feed();
    int i = 0;
    while (i < c_n) begin
      @(negedge clk); pl_valid = 1'b1; pl_data = pat(i); #1;
      if (pl_ready) i++;
    end
    @(negedge clk); pl_valid = 1'b0;
  endtask

  task automatic collect();
    int b = 0, cyc = 0;
    bit done = 1'b0, held = 1'b0;
    logic [511:0] hd;
    while (!done) begin
      @(negedge clk);
      m_ready = !c_stall || (cyc % 3 != 2);
      cyc++;
      #1;
      if (held) begin
        chk("R2 held beat", {m_valid, m_data[510:0]}, {1'b1, hd[510:0]});
        held = 1'b0;
      end
      if (m_valid) begin
        if (!m_ready) begin
          held = 1'b1; hd = m_data;
        end else begin
          logic [511:0] ed; logic [15:0] ek; logic [63:0] eb;
          for (int j = 0; j < 16; j++) begin
            int g = b * 16 + j;
            ed[j*32 +: 32] = e_dw(g);
            ek[j] = (g < e_len());
            eb[j*4 +: 4] = e_be(g);
          end
          chk("R1 R8 R9 R10 data", m_data, ed);
          chk("R3 keep", 512'(m_keep), 512'(ek));
          chk("R6 R7 byte enables", 512'(m_be), 512'(eb));
          chk("R4 R5 R11 flags", 512'({m_last, m_sop, m_first_be, m_last_be, req_ready}),
              512'({b == e_beats() - 1, b == 0, (b == 0) ? c_f : 4'h0,
                    (b == 0 && c_n >= 2) ? c_l : 4'h0, 1'b0}));
          b++;
          if (b >= e_beats()) done = 1'b1;
        end
      end
    end
    m_ready = 1'b1;
  endtask

  task automatic run_pkt(logic [61:0] a, int n, logic [3:0] f, logic [3:0] l, bit al, bit st);
    c_addr = a; c_n = n; c_f = f; c_l = l; c_al = al; c_stall = st;
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_dwords = 11'(n);
    req_first_be = f; req_last_be = l; req_aligned = al;
    #1; chk("R11 ready when idle", 512'(req_ready), 512'(1));
    @(negedge clk); req_valid = 1'b0; #1;
    chk("R11 ready low in packet", 512'(req_ready), 512'(0));
    chk("R7 payload port open only with payload", 512'(pl_ready), 512'(n != 0));
    fork
      feed();
      collect();
    join
    @(negedge clk); #1;
    chk("R11 ready after final beat", 512'(req_ready), 512'(1));
  endtask

  task automatic t_reset();
    #1;
    chk("R4 R11 reset state", 512'({m_valid, req_ready, pl_ready}), 512'(3'b010));
  endtask
  task automatic t_one_dw_dword_mode();  run_pkt(62'h0000_1234_5673, 1, 4'b0110, 4'b0000, 1'b0, 1'b0); endtask
  task automatic t_one_dw_addr_mode();   run_pkt(62'h0000_00AB_0007, 1, 4'b1110, 4'b0000, 1'b1, 1'b0); endtask
  task automatic t_two_dw();             run_pkt(62'h0000_0000_0F06, 2, 4'b1000, 4'b0001, 1'b1, 1'b0); endtask
  task automatic t_zero_len();           run_pkt(62'h0000_0000_0051, 0, 4'b0000, 4'b0000, 1'b1, 1'b0); endtask
  task automatic t_long_addr_stall();    run_pkt(62'h0001_0000_0123, 47, 4'b1000, 4'b0111, 1'b1, 1'b1); endtask
  task automatic t_long_dword_full();    run_pkt(62'h0000_0000_4003, 28, 4'b1100, 4'b0011, 1'b0, 1'b0); endtask
  task automatic t_exact_beat();         run_pkt(62'h0000_0000_0040, 12, 4'b1111, 4'b1111, 1'b1, 1'b1); endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_one_dw_dword_mode();
    t_one_dw_addr_mode();
    t_two_dw();
    t_zero_len();
    t_long_addr_stall();
    t_long_dword_full();
    t_exact_beat();
    all_done = 1'b1;
  end

  initial begin : watchdog
    int cnt = 0;
    while (!all_done && cnt < 100000) begin
      @(posedge clk); cnt++;
    end
    if (!all_done) begin
      total++; bad++;
      $display("FAIL R11 watchdog act=hung exp=finished");
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule